// File: doc/BRIEF.md
# Address-Masked APB General-Purpose I/O

This block is an eight-pin general-purpose I/O port that sits behind an APB slave. Each pin has its own direction bit and its own output bit. The block drives an output value and an output-enable for every pad, and it reads the pad level back through a two-flop synchroniser.

The output data register is not at a single address. It fills a window of 256 word addresses, and the word-address bits act as a per-pin mask. A read returns only the pins whose mask bits are set, and every other bit reads as zero. A write changes only the pins whose mask bits are set. Software can therefore set, clear or sample one pin, or any group of pins, in a single transfer, with no read-modify-write sequence and no race against other agents that touch the same port.

The APB side has zero wait states and never reports an error. The bus interface is plain APB, so no valid/ready back-pressure applies: every access completes in its access phase.

Top module: `gpio_apb_masked`

## Requirements
- R1: After reset, the direction register and the output register are both 0x00, so `pad_oe` and `pad_out` are 0x00. A full-mask read of the data window then returns the synchronised pad levels (all zero while the pads are low).
- R2: The direction register is at byte offset 0x400 and can be read and written at full width. Bit n = 1 makes pin n an output, and bit n = 0 makes it an input. `pad_oe` equals the direction register from the clock edge that ends the write.
- R3: Byte offsets 0x000 to 0x3FC form the data window, and PADDR[9:2] is the mask (PADDR[2+n] gates pin n). A write in the window loads PWDATA[n] into output bit n only where the mask bit is 1. Bits with a 0 mask keep their value. `pad_out` equals the output register.
- R4: A read in the window returns 0 in every bit whose mask bit is 0, whatever the pin level. Address 1<<(n+2) therefore returns only pin n.
- R5: For a read in the window with mask bit n = 1, a pin set as an output returns its output register bit. A pin set as an input returns `pad_in[n]` after two clock edges of synchronisation: a change is not visible after one edge and is visible after two.
- R6: Offsets outside the data window and outside the direction word (for example 0x404, 0x800, 0xFFC) read as 0x00, and writes to them change nothing.
- R7: `pready` is always 1 and `pslverr` is always 0.
- R8: Registers change only on a transfer with PSEL, PENABLE and PWRITE all high. A setup phase (PENABLE low), or PENABLE without PSEL, leaves both registers unchanged.
- R9: PADDR[1:0] are not decoded. Byte addresses 0x401 and 0x403 reach the direction register just as 0x400 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | APB byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is high |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The hardest situation to reach is a masked read that mixes pin types: some mask bits select output pins, whose value comes from the register, and others select input pins, whose value comes from the synchronised pad. A mask bit of zero must also hide a pin that is high. To reach it, the bench sets a mixed direction pattern and output and pad patterns that differ from each other, lets the synchroniser settle, and sweeps all 256 masks. Each result is compared with an expected value computed in the bench from the direction, output and pad values. A separate sequence holds a read open across single clock edges to show that a pad change is hidden after one edge and visible after two.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Register targeted by the current address
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_DIR  = 2'd2
  } rsel_e;

  localparam int WORD_LSB = 2;

endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_mask_pkg::*;
#(
  parameter int NPIN       = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFSET = 'h400
) (
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:WORD_LSB]   word_addr,
  output rsel_e                      sel,
  output logic [NPIN-1:0]            mask,
  output logic                       wr_stb
);

  localparam int                MASK_HI  = NPIN + WORD_LSB - 1;
  localparam int                WIN_LSB  = NPIN + WORD_LSB;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic in_window;
  logic hit_dir;

  assign mask      = word_addr[MASK_HI:WORD_LSB];
  assign in_window = (word_addr[ADDR_W-1:WIN_LSB] == '0);
  assign hit_dir   = (word_addr == DIR_ADDR[ADDR_W-1:WORD_LSB]);
  assign wr_stb    = psel & penable & pwrite;

  always_comb begin
    if (in_window)    sel = RSEL_DATA;
    else if (hit_dir) sel = RSEL_DIR;
    else              sel = RSEL_NONE;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_mask_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rsel_e           sel,
  input  logic [NPIN-1:0] mask,
  input  logic            wr_stb,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] pin_sync,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] rdata
);

  logic            dir_wr;
  logic            dat_wr;
  logic [NPIN-1:0] pin_val;

  assign dir_wr = wr_stb && (sel == RSEL_DIR);
  assign dat_wr = wr_stb && (sel == RSEL_DATA);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[i] <= 1'b0;
        out_q[i] <= 1'b0;
      end else begin
        if (dir_wr)             dir_q[i] <= wdata[i];
        if (dat_wr && mask[i])  out_q[i] <= wdata[i];
      end
    end
    // Output pins read back their register, input pins their pad
    assign pin_val[i] = dir_q[i] ? out_q[i] : pin_sync[i];
  end

  always_comb begin
    unique case (sel)
      RSEL_DATA: rdata = pin_val & mask;
      RSEL_DIR:  rdata = dir_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_apb_masked.sv
module gpio_apb_masked
  import gpio_mask_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int ADDR_W      = 12,
  parameter int DIR_OFFSET  = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NPIN-1:0]   pwdata,
  output logic [NPIN-1:0]   prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);

  rsel_e           sel;
  logic [NPIN-1:0] mask;
  logic            wr_stb;
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] bank_rdata;
  logic            addr_lo_unused;

  assign addr_lo_unused = ^paddr[WORD_LSB-1:0];

  gpio_apb_decode #(
    .NPIN       (NPIN),
    .ADDR_W     (ADDR_W),
    .DIR_OFFSET (DIR_OFFSET)
  ) u_decode (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .word_addr (paddr[ADDR_W-1:WORD_LSB]),
    .sel       (sel),
    .mask      (mask),
    .wr_stb    (wr_stb)
  );

  gpio_in_sync #(
    .W      (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (pclk),
    .rst_n (presetn),
    .din   (pad_in),
    .dout  (pin_sync)
  );

  gpio_pin_bank #(
    .NPIN (NPIN)
  ) u_bank (
    .clk      (pclk),
    .rst_n    (presetn),
    .sel      (sel),
    .mask     (mask),
    .wr_stb   (wr_stb),
    .wdata    (pwdata),
    .pin_sync (pin_sync),
    .dir_q    (pad_oe),
    .out_q    (pad_out),
    .rdata    (bank_rdata)
  );

  assign prdata  = psel ? bank_rdata : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_apb_masked_chk.sv
module gpio_apb_masked_chk #(
  parameter int NPIN       = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFSET = 'h400
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [NPIN-1:0]   pwdata,
  input logic [NPIN-1:0]   prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe
);

  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic            wr_acc;
  logic            in_win;
  logic            is_dir;
  logic [NPIN-1:0] amask;
  logic            pad_in_unused;

  assign pad_in_unused = ^pad_in;
  assign wr_acc = psel && penable && pwrite;
  assign in_win = (paddr[ADDR_W-1:NPIN+2] == '0);
  assign is_dir = (paddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
  assign amask  = paddr[NPIN+1:2];

  p_bus_ok_r7: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  p_oe_load_r2: assert property (@(posedge pclk) disable iff (!presetn)
    wr_acc && is_dir |=> pad_oe == $past(pwdata));

  p_mask_set_r3: assert property (@(posedge pclk) disable iff (!presetn)
    wr_acc && in_win |=> ((pad_out ^ $past(pwdata)) & $past(amask)) == '0);

  p_mask_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
    wr_acc && in_win |=> ((pad_out ^ $past(pad_out)) & ~$past(amask)) == '0);

  p_idle_hold_r8: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_acc |=> $stable(pad_out) && $stable(pad_oe));

  p_unmapped_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
    wr_acc && !in_win && !is_dir |=> $stable(pad_out) && $stable(pad_oe));

  p_rd_mask_r4: assert property (@(posedge pclk) disable iff (!presetn)
    psel && !pwrite && in_win |-> (prdata & ~amask) == '0);

  p_rd_unmapped_r6: assert property (@(posedge pclk) disable iff (!presetn)
    psel && !in_win && !is_dir |-> prdata == '0);

  p_rd_out_r5: assert property (@(posedge pclk) disable iff (!presetn)
    psel && !pwrite && in_win |-> ((prdata ^ pad_out) & amask & pad_oe) == '0);

endmodule

bind gpio_apb_masked gpio_apb_masked_chk #(
  .NPIN       (NPIN),
  .ADDR_W     (ADDR_W),
  .DIR_OFFSET (DIR_OFFSET)
) u_chk (.*);

// File: tb/tb_gpio_apb_masked.sv
`timescale 1ns/1ps
module tb_gpio_apb_masked;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic        pready, pslverr;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  always #2 pclk = ~pclk;

  gpio_apb_masked dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd, exp_out, dirp, outp, pinp;
    repeat (3) @(negedge pclk);
    presetn = 1;
    repeat (3) @(negedge pclk);

    // R1 reset values, R7 bus status
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    apb_read(12'h400, rd); check("R1 dir read", rd, 8'h00);
    apb_read(12'h3FC, rd); check("R1 data read", rd, 8'h00);
    check("R7 pready", {7'b0, pready}, 8'h01);
    check("R7 pslverr", {7'b0, pslverr}, 8'h00);

    // R2 direction register
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      v = 8'((k * 73 + 5) & 255);
      apb_write(12'h400, v);
      check("R2 pad_oe", pad_oe, v);
      apb_read(12'h400, rd); check("R2 dir readback", rd, v);
    end

    // R9 low address bits ignored
    apb_write(12'h403, 8'h5A);
    check("R9 pad_oe via 0x403", pad_oe, 8'h5A);
    apb_read(12'h401, rd); check("R9 read via 0x401", rd, 8'h5A);

    // R3 masked write sweep, all pins output
    apb_write(12'h400, 8'hFF);
    exp_out = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d, mk;
      mk = 8'(m);
      d = 8'((m * 37 + 11) & 255);
      apb_write({2'b00, mk, 2'b00}, d);
      exp_out = (exp_out & ~mk) | (d & mk);
      check("R3 masked write", pad_out, exp_out);
      if ((m % 16) == 15) begin
        apb_read(12'h3FC, rd); check("R5 output readback", rd, exp_out);
      end
    end

    // R4/R5 masked read sweep with mixed directions
    dirp = 8'hA5; outp = 8'h3C; pinp = 8'h96;
    apb_write(12'h400, dirp);
    apb_write(12'h3FC, outp);
    pad_in = pinp;
    repeat (3) @(negedge pclk);
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mk;
      mk = 8'(m);
      apb_read({2'b00, mk, 2'b00}, rd);
      check("R4 R5 masked read", rd, mk & ((dirp & outp) | (~dirp & pinp)));
    end
    // single-pin read addresses
    for (int n = 0; n < 8; n++) begin
      logic [7:0] bit_n;
      bit_n = 8'(1 << n);
      apb_read(12'(1 << (n + 2)), rd);
      check("R4 single pin read", rd, bit_n & ((dirp & outp) | (~dirp & pinp)));
    end

    // R5 synchroniser latency: all inputs, full-mask read held open
    apb_write(12'h400, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge pclk);
    psel = 1; pwrite = 0; paddr = 12'h3FC; penable = 0;
    @(negedge pclk); penable = 1;
    pad_in = 8'hC3;
    #1 check("R5 sync no edge", prdata, 8'h00);
    @(negedge pclk); #1 check("R5 sync one edge", prdata, 8'h00);
    @(negedge pclk); #1 check("R5 sync two edges", prdata, 8'hC3);
    @(negedge pclk); psel = 0; penable = 0;

    // R6 unmapped offsets
    apb_write(12'h400, 8'h0F);
    apb_write(12'h3FC, 8'h66);
    apb_write(12'h404, 8'hFF);
    apb_write(12'h800, 8'hFF);
    apb_write(12'hFFC, 8'h00);
    apb_write(12'hC00, 8'hAA);
    check("R6 pad_oe unchanged", pad_oe, 8'h0F);
    check("R6 pad_out unchanged", pad_out, 8'h66);
    apb_read(12'h404, rd); check("R6 read 0x404", rd, 8'h00);
    apb_read(12'h800, rd); check("R6 read 0x800", rd, 8'h00);
    apb_read(12'hFFC, rd); check("R6 read 0xFFC", rd, 8'h00);

    // R8 setup phase only, and enable without select
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h3FC; pwdata = 8'h99;
    repeat (3) @(negedge pclk);
    psel = 0; penable = 1; paddr = 12'h400; pwdata = 8'hF0;
    repeat (3) @(negedge pclk);
    penable = 0; pwrite = 0;
    check("R8 pad_out held", pad_out, 8'h66);
    check("R8 pad_oe held", pad_oe, 8'h0F);

    // R1 reset again clears registers
    presetn = 0;
    @(negedge pclk);
    check("R1 reset clears out", pad_out, 8'h00);
    check("R1 reset clears oe", pad_oe, 8'h00);
    presetn = 1;
    @(negedge pclk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule